// File: doc/BRIEF.md
# SHA-512 Message Sequencer

The sequencer runs one hashing request over a byte string held in memory. It first fetches a 64-byte chaining value from a parameter area. It then streams the message through a byte-wide synchronous read port and packs it into 128-byte blocks. Each block goes to an external compression engine together with the current chaining value. The engine returns the next chaining value.

When the work is finished, the sequencer stores the chaining value back into the parameter area. It then reports the updated message address and length registers, a condition code and a specification fault flag.

There are two request types. An intermediate request consumes whole blocks only and rejects any length that is not block aligned. A final request also pads the trailing bytes. The padding uses the 128-bit message bit count stored in the parameter area, and it adds one extra block when the tail leaves no room for that count. A single request handles a bounded number of whole blocks. If input is left over, the request ends with a partial-completion code so that the caller can issue it again.

Top module: `sha512_msg_seq`

## Requirements
- R1: An intermediate request (`last_mode`=0) whose effective length is not a multiple of 128 sets `spec_fault`. It reads no memory, starts no compression and writes nothing. It returns the address and length registers unchanged, with `cc`=0.
- R2: The chaining value is read from parameter bytes 0..63. Byte k of the area is presented on `cmp_cv[511-8k -: 8]`. At completion the final chaining value is written back, byte k to parameter address + k.
- R3: A whole block k holds message bytes at message address + 128k + i. Byte i is placed on `cmp_blk[1023-8i -: 8]`. Blocks are sent in address order, and each result from the engine becomes the next chaining value.
- R4: A request compresses at most 64 whole blocks. If at least 128 bytes still remain, `cc` is 3. Otherwise, after any final-mode padding, `cc` is 0.
- R5: In a final request, the tail of r < 128 bytes is copied to block bytes 0..r-1. Byte r is set to 0x80, and all other bytes are zero except those that hold the bit count.
- R6: The 16-byte bit count at parameter offsets 64..79 fills block bytes 112..127 of the padded block when r < 112.
- R7: When 112 <= r <= 127, the padded block is sent without the bit count. A second block follows, made of 112 zero bytes and then the bit count.
- R8: A final request of length zero sends exactly one block: 0x80 in byte 0, zeros, then the bit count.
- R9: `amode` selects the addressing mode: 00 is 24-bit, 01 is 31-bit, and 1x is 64-bit. Outside 64-bit mode only the low 32 bits of `msg_len` count. The updated address changes only its low 24 bits (24-bit mode) or low 32 bits (31-bit mode). The updated length is the full `msg_len` minus the bytes processed.
- R10: Every read and write address is wrapped to the addressing mode: low 24 bits in 24-bit mode, low 31 bits in 31-bit mode.
- R11: `busy` is high from the cycle after an accepted `start` until `done` pulses. All 64 writes finish before `done`. `cc`, `spec_fault` and the updated registers hold their values until the next `start`. After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request pulse, accepted while idle |
| last_mode | input | 1 | 1 selects a final (padding) request, 0 an intermediate request |
| amode | input | 2 | Addressing mode: 00 = 24-bit, 01 = 31-bit, 1x = 64-bit |
| param_addr | input | 64 | Base of the parameter area |
| msg_addr | input | 64 | Message address register |
| msg_len | input | 64 | Message length register, in bytes |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| cc | output | 2 | Condition code: 0 = complete, 3 = partial |
| spec_fault | output | 1 | Misaligned intermediate length |
| msg_addr_upd | output | 64 | Updated message address register |
| msg_len_upd | output | 64 | Updated message length register |
| rd_en | output | 1 | Memory byte read request |
| rd_addr | output | 64 | Read address |
| rd_data | input | 8 | Read data, valid the cycle after `rd_en` |
| wr_en | output | 1 | Memory byte write |
| wr_addr | output | 64 | Write address |
| wr_data | output | 8 | Write data |
| cmp_start | output | 1 | Compression request pulse |
| cmp_cv | output | 512 | Chaining value to the engine |
| cmp_blk | output | 1024 | Message block to the engine |
| cmp_done | input | 1 | Engine result valid pulse |
| cmp_result | input | 512 | Next chaining value from the engine |

## Verification
The bench targets the tail lengths around the bit-count boundary: 0, 5, 111, 112 and 127. A design that tested the boundary the wrong way would either overwrite tail bytes with the bit count or drop the second block. It also runs a request of 65 whole blocks and one of 64 blocks plus a short tail. A broken block limit would return the wrong condition code or would skip the tail that must still be padded.

Requests in 24-bit and 31-bit modes place both areas just below the wrap point and pass lengths with junk in the upper 32 bits. Missing wrapping would fetch bytes from the wrong addresses, and a wrong register merge would corrupt the upper address bits or the reported length. A misaligned intermediate request checks that a faulting request leaves memory and both registers untouched.

// File: rtl/sha512_seq_pkg.sv
// Shared types and helpers for the SHA-512 message sequencer.
// Assumes byte-addressed memory and 64-bit register images.
package sha512_seq_pkg;

    localparam int BLK_BYTES = 128;
    localparam int CV_BYTES  = 64;
    localparam int CNT_BYTES = 16;
    localparam int PAD_LIMIT = 112;

    typedef enum logic [3:0] {
        S_IDLE, S_CV, S_MBL, S_DECIDE, S_BLK, S_TAIL,
        S_PAD, S_GO, S_WAIT, S_WR, S_END
    } seq_state_t;

    typedef enum logic [1:0] {
        K_FULL, K_PAD1, K_PAD2
    } blk_kind_t;

    // Wrap an address to the addressing mode (00: 24-bit, 01: 31-bit, 1x: 64-bit).
    function automatic logic [63:0] wrap_addr(input logic [63:0] a, input logic [1:0] am);
        case (am)
            2'b00:   return {40'h0, a[23:0]};
            2'b01:   return {33'h0, a[30:0]};
            default: return a;
        endcase
    endfunction

endpackage

// File: rtl/sha_byte_reg.sv
// Byte-addressable register file with a clear and a parallel load.
// Byte 0 sits in the most significant position of q.
// Assumes clr has priority over ld, and ld over a single-byte write.
module sha_byte_reg #(
    parameter int NB = 64,
    parameter int IW = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            ld,
    input  logic [NB*8-1:0] ld_data,
    input  logic            we,
    input  logic [IW-1:0]   widx,
    input  logic [7:0]      wbyte,
    output logic [NB*8-1:0] q
);
    for (genvar g = 0; g < NB; g++) begin : g_byte
        // Update one byte lane from the clear, load or write source.
        always_ff @(posedge clk) begin
            if (!rst_n || clr)
                q[NB*8-1-8*g -: 8] <= 8'h00;
            else if (ld)
                q[NB*8-1-8*g -: 8] <= ld_data[NB*8-1-8*g -: 8];
            else if (we && (widx == IW'(g)))
                q[NB*8-1-8*g -: 8] <= wbyte;
        end
    end
endmodule

// File: rtl/sha_rd_stream.sv
// Issues `count` consecutive byte reads from base, wrapped to the
// addressing mode, and reports each returned byte with its index.
// Assumes one-cycle read latency and run held high until fin.
module sha_rd_stream
    import sha512_seq_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [63:0]   base,
    input  logic [CW-1:0] count,
    input  logic [1:0]    am,
    output logic          rd_en,
    output logic [63:0]   rd_addr,
    output logic          cap_we,
    output logic [CW-2:0] cap_idx,
    output logic          fin
);
    logic [CW-1:0] issue_idx;
    logic [CW-1:0] pend_idx;
    logic          pend;

    // Request the next byte while the phase has bytes left to issue.
    always_comb begin
        rd_en   = run && (issue_idx < count);
        rd_addr = wrap_addr(base + 64'(issue_idx), am);
        cap_we  = pend;
        cap_idx = pend_idx[CW-2:0];
        fin     = pend && (pend_idx == count - CW'(1));
    end

    // Track the issue index and which byte returns in the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || fin) begin
            issue_idx <= '0;
            pend      <= 1'b0;
            pend_idx  <= '0;
        end else begin
            if (rd_en) issue_idx <= issue_idx + CW'(1);
            pend     <= rd_en;
            pend_idx <= issue_idx;
        end
    end

    // R3
    cap_follows_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_we |-> $past(rd_en));
endmodule

// File: rtl/sha512_msg_seq.sv
// Sequences one SHA-512 intermediate or final request: fetches the
// chaining value and message bytes, pads the tail in final mode,
// drives the external compression engine, stores the result and
// reports the updated registers with a condition code.
// Assumes a one-cycle byte read port and an engine that returns
// cmp_done at least one cycle after cmp_start.
module sha512_msg_seq
    import sha512_seq_pkg::*;
#(
    parameter int MAX_BLOCKS = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          last_mode,
    input  logic [1:0]    amode,
    input  logic [63:0]   param_addr,
    input  logic [63:0]   msg_addr,
    input  logic [63:0]   msg_len,
    output logic          busy,
    output logic          done,
    output logic [1:0]    cc,
    output logic          spec_fault,
    output logic [63:0]   msg_addr_upd,
    output logic [63:0]   msg_len_upd,
    output logic          rd_en,
    output logic [63:0]   rd_addr,
    input  logic [7:0]    rd_data,
    output logic          wr_en,
    output logic [63:0]   wr_addr,
    output logic [7:0]    wr_data,
    output logic          cmp_start,
    output logic [511:0]  cmp_cv,
    output logic [1023:0] cmp_blk,
    input  logic          cmp_done,
    input  logic [511:0]  cmp_result
);
    localparam int CVW  = CV_BYTES * 8;
    localparam int BLKW = BLK_BYTES * 8;
    localparam int CNW  = CNT_BYTES * 8;
    localparam int NBW  = $clog2(MAX_BLOCKS + 1);
    localparam int CW   = $clog2(BLK_BYTES) + 1;
    localparam int WIW  = $clog2(CV_BYTES);

    seq_state_t     st;
    blk_kind_t      kind;
    logic           last_q, flt, ovl;
    logic [1:0]     am_q;
    logic [63:0]    par_q, addr_q, len_q, rem, proc_n;
    logic [NBW-1:0] nblk;
    logic [WIW-1:0] wr_idx;

    logic           rd_run, cap_we, fin;
    logic [63:0]    rd_base;
    logic [CW-1:0]  rd_cnt;
    logic [CW-2:0]  cap_idx;
    logic [CVW-1:0] cv_q;
    logic [BLKW-1:0] blk_q;
    logic [CNW-1:0] cnt_q;
    logic           blk_clr, blk_we, cv_ld;
    logic [CW-2:0]  blk_widx;
    logic [7:0]     blk_wbyte;
    logic [63:0]    len_eff, addr_sum;
    logic           go_blk, go_tail;

    // Effective length at start: low 32 bits outside 64-bit mode.
    assign len_eff = amode[1] ? msg_len : {32'h0, msg_len[31:0]};

    // Pick the read phase source and size from the state.
    always_comb begin
        rd_run  = (st == S_CV) || (st == S_MBL) || (st == S_BLK) || (st == S_TAIL);
        rd_base = addr_q + proc_n;
        rd_cnt  = CW'(BLK_BYTES);
        case (st)
            S_CV:    begin rd_base = par_q;                   rd_cnt = CW'(CV_BYTES);  end
            S_MBL:   begin rd_base = par_q + 64'(CV_BYTES);   rd_cnt = CW'(CNT_BYTES); end
            S_TAIL:  rd_cnt = rem[CW-1:0];
            default: ;
        endcase
    end

    sha_rd_stream #(.CW(CW)) u_rd (
        .clk(clk), .rst_n(rst_n), .run(rd_run), .base(rd_base), .count(rd_cnt),
        .am(am_q), .rd_en(rd_en), .rd_addr(rd_addr), .cap_we(cap_we),
        .cap_idx(cap_idx), .fin(fin)
    );

    // Route captured bytes and padding marks into the block store.
    always_comb begin
        go_blk    = (st == S_DECIDE) && (rem >= 64'(BLK_BYTES)) && (nblk != NBW'(MAX_BLOCKS));
        go_tail   = (st == S_DECIDE) && (rem < 64'(BLK_BYTES)) && last_q;
        blk_clr   = go_blk || go_tail ||
                    ((st == S_WAIT) && cmp_done && (kind == K_PAD1) && (rem >= 64'(PAD_LIMIT)));
        blk_we    = (cap_we && ((st == S_BLK) || (st == S_TAIL))) || (st == S_PAD);
        blk_widx  = (st == S_PAD) ? rem[CW-2:0] : cap_idx;
        blk_wbyte = (st == S_PAD) ? 8'h80 : rd_data;
        cv_ld     = (st == S_WAIT) && cmp_done;
    end

    sha_byte_reg #(.NB(CV_BYTES), .IW(CW-1)) u_cv (
        .clk(clk), .rst_n(rst_n), .clr(1'b0), .ld(cv_ld), .ld_data(cmp_result),
        .we(cap_we && (st == S_CV)), .widx(cap_idx), .wbyte(rd_data), .q(cv_q)
    );

    sha_byte_reg #(.NB(CNT_BYTES), .IW(CW-1)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(1'b0), .ld(1'b0), .ld_data('0),
        .we(cap_we && (st == S_MBL)), .widx(cap_idx), .wbyte(rd_data), .q(cnt_q)
    );

    sha_byte_reg #(.NB(BLK_BYTES), .IW(CW-1)) u_blk (
        .clk(clk), .rst_n(rst_n), .clr(blk_clr), .ld(1'b0), .ld_data('0),
        .we(blk_we), .widx(blk_widx), .wbyte(blk_wbyte), .q(blk_q)
    );

    // Drive engine, write port and status from the registered state.
    always_comb begin
        cmp_start = (st == S_GO);
        cmp_cv    = cv_q;
        cmp_blk   = ovl ? {blk_q[BLKW-1:CNW], cnt_q} : blk_q;
        wr_en     = (st == S_WR);
        wr_addr   = wrap_addr(par_q + 64'(wr_idx), am_q);
        wr_data   = cv_q[CVW-1-8*int'(wr_idx) -: 8];
        busy      = (st != S_IDLE);
        addr_sum  = addr_q + proc_n;
    end

    // Main sequence: fetch, compress, pad, store, report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE;       kind <= K_FULL;   last_q <= 1'b0; flt <= 1'b0;
            ovl <= 1'b0;        am_q <= 2'b00;    par_q <= '0;    addr_q <= '0;
            len_q <= '0;        rem <= '0;        proc_n <= '0;   nblk <= '0;
            wr_idx <= '0;       done <= 1'b0;     cc <= 2'd0;     spec_fault <= 1'b0;
            msg_addr_upd <= '0; msg_len_upd <= '0;
        end else begin
            done <= (st == S_END);
            case (st)
                S_IDLE: if (start) begin
                    last_q <= last_mode;  am_q <= amode;   par_q <= param_addr;
                    addr_q <= msg_addr;   len_q <= msg_len; rem <= len_eff;
                    proc_n <= '0;         nblk <= '0;       wr_idx <= '0;
                    ovl <= 1'b0;          cc <= 2'd0;       spec_fault <= 1'b0;
                    flt <= !last_mode && (len_eff[6:0] != 7'd0);
                    st  <= (!last_mode && (len_eff[6:0] != 7'd0)) ? S_END : S_CV;
                end
                S_CV:   if (fin) st <= last_q ? S_MBL : S_DECIDE;
                S_MBL:  if (fin) st <= S_DECIDE;
                S_DECIDE: begin
                    if (go_blk)                        st <= S_BLK;
                    else if (go_tail && rem == 64'd0)  st <= S_PAD;
                    else if (go_tail)                  st <= S_TAIL;
                    else                               st <= S_WR;
                end
                S_BLK:  if (fin) begin kind <= K_FULL; ovl <= 1'b0; st <= S_GO; end
                S_TAIL: if (fin) st <= S_PAD;
                S_PAD: begin
                    ovl  <= (rem < 64'(PAD_LIMIT));
                    kind <= K_PAD1;
                    st   <= S_GO;
                end
                S_GO:   st <= S_WAIT;
                S_WAIT: if (cmp_done) begin
                    if (kind == K_FULL) begin
                        rem    <= rem - 64'(BLK_BYTES);
                        proc_n <= proc_n + 64'(BLK_BYTES);
                        nblk   <= nblk + NBW'(1);
                        st     <= S_DECIDE;
                    end else if (kind == K_PAD1 && rem >= 64'(PAD_LIMIT)) begin
                        ovl  <= 1'b1;
                        kind <= K_PAD2;
                        st   <= S_GO;
                    end else begin
                        proc_n <= proc_n + rem;
                        rem    <= '0;
                        st     <= S_WR;
                    end
                end
                S_WR: begin
                    wr_idx <= wr_idx + WIW'(1);
                    if (wr_idx == WIW'(CV_BYTES - 1)) st <= S_END;
                end
                S_END: begin
                    spec_fault  <= flt;
                    cc          <= (!flt && rem != 64'd0) ? 2'd3 : 2'd0;
                    msg_len_upd <= len_q - proc_n;
                    case (am_q)
                        2'b00:   msg_addr_upd <= {addr_q[63:24], addr_sum[23:0]};
                        2'b01:   msg_addr_upd <= {addr_q[63:32], addr_sum[31:0]};
                        default: msg_addr_upd <= addr_sum;
                    endcase
                    st <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // Count compressions in the current request for the limit check.
    logic [NBW+1:0] cmp_seen;
    always_ff @(posedge clk) begin
        if (!rst_n || (st == S_IDLE)) cmp_seen <= '0;
        else if (cmp_start)           cmp_seen <= cmp_seen + 1'b1;
    end

    // R4
    blocks_per_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_start |-> (cmp_seen < (NBW+2)'(MAX_BLOCKS + 2)));
    // R10
    rd_wrap24_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && am_q == 2'b00) |-> (rd_addr[63:24] == 40'h0));
    // R10
    wr_wrap31_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && am_q == 2'b01) |-> (wr_addr[63:31] == 33'h0));
    // R1
    fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && flt) |-> (!rd_en && !wr_en && !cmp_start));
    // R11
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R11
    status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(cc) && $stable(spec_fault) && $stable(msg_len_upd)));
    // R11
    port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && wr_en));
endmodule

// File: tb/sha512_msg_seq_test.sv
module sha512_msg_seq_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          start = 1'b0, last_mode = 1'b0;
    logic [1:0]    amode = 2'b10;
    logic [63:0]   param_addr = '0, msg_addr = '0, msg_len = '0;
    logic          busy, done, spec_fault, rd_en, wr_en, cmp_start;
    logic [1:0]    cc;
    logic [63:0]   msg_addr_upd, msg_len_upd, rd_addr, wr_addr;
    logic [7:0]    wr_data;
    logic [7:0]    rd_data = 8'h00;
    logic [511:0]  cmp_cv;
    logic [1023:0] cmp_blk;
    logic          cmp_done = 1'b0;
    logic [511:0]  cmp_result = '0;

    sha512_msg_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .last_mode(last_mode), .amode(amode),
        .param_addr(param_addr), .msg_addr(msg_addr), .msg_len(msg_len),
        .busy(busy), .done(done), .cc(cc), .spec_fault(spec_fault),
        .msg_addr_upd(msg_addr_upd), .msg_len_upd(msg_len_upd),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cmp_start(cmp_start), .cmp_cv(cmp_cv), .cmp_blk(cmp_blk),
        .cmp_done(cmp_done), .cmp_result(cmp_result)
    );

    int n_tot = 0, n_fail = 0;
    int wcount, nlog, eng_t;
    bit eng_busy;
    logic [7:0]    wmem [logic [63:0]];
    logic [1023:0] blk_log [0:69];
    logic [511:0]  cv_first;

    logic [1023:0] exp_blk [0:69];
    int            exp_n;
    logic [511:0]  exp_cv, cv_init;
    logic [63:0]   exp_proc;
    logic [1:0]    exp_cc;
    bit            exp_fault;

    // Memory contents are a fixed function of the full address.
    function automatic logic [7:0] mrd(input logic [63:0] a);
        return 8'(a * 13 + (a >> 9) + (a >> 24) + (a >> 40));
    endfunction

    function automatic logic [63:0] wrapa(input logic [63:0] a, input logic [1:0] am);
        if (am == 2'b00) return a & 64'hFF_FFFF;
        if (am == 2'b01) return a & 64'h7FFF_FFFF;
        return a;
    endfunction

    // Stand-in compression engine: order-sensitive mix of cv and block.
    function automatic logic [511:0] engf(input logic [511:0] c, input logic [1023:0] b);
        return {c[510:0], c[511]} ^ b[1023:512] ^ b[511:0];
    endfunction

    // Memory, write log and engine model.
    always @(posedge clk) begin
        cmp_done <= 1'b0;
        if (rd_en) rd_data <= mrd(rd_addr);
        if (start) begin wmem.delete(); wcount = 0; nlog = 0; eng_busy = 0; end
        if (wr_en) begin wmem[wr_addr] = wr_data; wcount++; end
        if (cmp_start) begin
            if (nlog < 70) blk_log[nlog] = cmp_blk;
            if (nlog == 0) cv_first = cmp_cv;
            nlog++;
            cmp_result <= engf(cmp_cv, cmp_blk);
            eng_busy = 1; eng_t = 2;
        end else if (eng_busy) begin
            if (eng_t == 0) begin cmp_done <= 1'b1; eng_busy = 0; end
            else eng_t--;
        end
    end

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_tot++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [1023:0] b);
        if (exp_n < 70) exp_blk[exp_n] = b;
        exp_cv = engf(exp_cv, b);
        exp_n++;
    endtask

    // Reference model built from the requirements.
    task automatic model(input bit lst, input logic [1:0] am, input logic [63:0] par, input logic [63:0] adr, input logic [63:0] len);
        logic [63:0]   le, rem;
        logic [1023:0] b;
        logic [127:0]  mbl;
        int            r;
        le = am[1] ? len : {32'h0, len[31:0]};
        exp_fault = !lst && (le[6:0] != 7'd0);
        exp_n = 0; exp_proc = 0; exp_cc = 2'd0;
        for (int i = 0; i < 64; i++) exp_cv[511-8*i -: 8] = mrd(wrapa(par + 64'(i), am));
        cv_init = exp_cv;
        if (exp_fault) return;
        for (int i = 0; i < 16; i++) mbl[127-8*i -: 8] = mrd(wrapa(par + 64'(64 + i), am));
        rem = le;
        while (rem >= 128 && exp_n < 64) begin
            for (int i = 0; i < 128; i++) b[1023-8*i -: 8] = mrd(wrapa(adr + exp_proc + 64'(i), am));
            push(b);
            rem -= 128; exp_proc += 128;
        end
        if (lst && rem < 128) begin
            r = int'(rem);
            b = '0;
            for (int i = 0; i < r; i++) b[1023-8*i -: 8] = mrd(wrapa(adr + exp_proc + 64'(i), am));
            b[1023-8*r -: 8] = 8'h80;
            if (r < 112) b[127:0] = mbl;
            push(b);
            if (r >= 112) begin b = '0; b[127:0] = mbl; push(b); end
            exp_proc += rem; rem = 0;
        end
        exp_cc = (rem != 0) ? 2'd3 : 2'd0;
    endtask

    // Run one request and check every visible result against the model.
    task automatic run_case(input string req, input bit lst, input logic [1:0] am,
                            input logic [63:0] par, input logic [63:0] adr, input logic [63:0] len);
        int cyc, mism;
        logic [63:0] sum, ea;
        model(lst, am, par, adr, len);
        @(negedge clk);
        last_mode = lst; amode = am; param_addr = par; msg_addr = adr; msg_len = len; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R11", "busy after start", 64'(busy), 64'd1);
        cyc = 0;
        while (!done && cyc < 60000) begin @(negedge clk); cyc++; end
        if (!done) begin
            n_tot++; n_fail++;
            $display("FAIL R11 watchdog actual=%0d expected=done", cyc);
            return;
        end
        chk("R1", "spec_fault", 64'(spec_fault), 64'(exp_fault));
        chk("R4", "block count", 64'(nlog), 64'(exp_n));
        mism = 0;
        for (int i = 0; i < exp_n && i < 70; i++) if (blk_log[i] !== exp_blk[i]) mism++;
        chk(req, "block contents", 64'(mism), 64'd0);
        if (!exp_fault) chk("R2", "initial chaining value", 64'(cv_first !== cv_init), 64'd0);
        chk("R11", "write count at done", 64'(wcount), exp_fault ? 64'd0 : 64'd64);
        if (!exp_fault) begin
            mism = 0;
            for (int i = 0; i < 64; i++) begin
                ea = wrapa(par + 64'(i), am);
                if (!wmem.exists(ea) || wmem[ea] !== exp_cv[511-8*i -: 8]) mism++;
            end
            chk("R2", "chaining value writeback", 64'(mism), 64'd0);
        end
        chk("R4", "condition code", 64'(cc), 64'(exp_cc));
        sum = adr + exp_proc;
        if (am == 2'b00)      ea = {adr[63:24], sum[23:0]};
        else if (am == 2'b01) ea = {adr[63:32], sum[31:0]};
        else                  ea = sum;
        chk("R9", "address update", msg_addr_upd, ea);
        chk("R9", "length update", msg_len_upd, len - exp_proc);
    endtask

    task automatic t_reset;
        chk("R11", "reset busy", 64'(busy), 64'd0);
        chk("R11", "reset done", 64'(done), 64'd0);
        chk("R11", "reset cc", 64'(cc), 64'd0);
        chk("R11", "reset fault", 64'(spec_fault), 64'd0);
        chk("R11", "reset ports", 64'({rd_en, wr_en, cmp_start}), 64'd0);
    endtask

    task automatic t_whole_blocks;   run_case("R3", 1'b0, 2'b10, 64'h1000, 64'h2000, 64'd256);      endtask
    task automatic t_misaligned;     run_case("R1", 1'b0, 2'b10, 64'h1000, 64'h2000, 64'd200);      endtask
    task automatic t_short_tail;     run_case("R5", 1'b1, 2'b10, 64'h1100, 64'h2345, 64'd5);        endtask
    task automatic t_zero_len;       run_case("R8", 1'b1, 2'b10, 64'h1200, 64'h3000, 64'd0);        endtask
    task automatic t_tail_111;       run_case("R6", 1'b1, 2'b10, 64'h1300, 64'h3100, 64'd111);      endtask
    task automatic t_tail_112;       run_case("R7", 1'b1, 2'b10, 64'h1400, 64'h3200, 64'd112);      endtask
    task automatic t_tail_127;       run_case("R7", 1'b1, 2'b10, 64'h1500, 64'h3300, 64'd127);      endtask
    task automatic t_block_and_tail; run_case("R5", 1'b1, 2'b10, 64'h1600, 64'h3400, 64'd130);      endtask
    task automatic t_limit_imd;      run_case("R4", 1'b0, 2'b11, 64'h1700, 64'h8000, 64'd8320);     endtask
    task automatic t_limit_last;     run_case("R4", 1'b1, 2'b10, 64'h1800, 64'h9000, 64'd8195);     endtask
    task automatic t_wrap24;
        run_case("R10", 1'b1, 2'b00, 64'h5500_0000_00FF_FFE0, 64'hAB00_0000_00FF_FFF0, 64'h1_0000_0085);
    endtask
    task automatic t_wrap31;
        run_case("R10", 1'b0, 2'b01, 64'h0000_0000_7FFF_FFE8, 64'hCD00_0000_7FFF_FFC0, 64'hFF_0000_0100);
    endtask

    task automatic t_hold;
        repeat (5) @(negedge clk);
        chk("R11", "cc held", 64'(cc), 64'(exp_cc));
        chk("R11", "length held", msg_len_upd, 64'hFF_0000_0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_whole_blocks;
        t_misaligned;
        t_short_tail;
        t_zero_len;
        t_tail_111;
        t_tail_112;
        t_tail_127;
        t_block_and_tail;
        t_limit_imd;
        t_limit_last;
        t_wrap24;
        t_wrap31;
        t_hold;
        $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_tot++; n_fail++;
        $display("FAIL R11 global watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
        $finish;
    end
endmodule